// File: doc/BRIEF.md
# Delayed-Sample Mismatch Window Counter

This block measures how much the phase of a free-running sampled oscillator wanders, working only from the digital bits produced by a sampler. The bits arrive one per sampling-clock cycle. Each accepted bit enters a long history register. The block then compares the bit with the bit a fixed number of accepted samples earlier, and marks a mismatch when the two differ. It sums the mismatches over back-to-back windows of fixed length. At the end of each window it emits the window total as a one-cycle result.

A downstream variance stage reads the stream of window totals. When jitter accumulates, the totals spread around a mean. That mean depends on the frequency ratio of the oscillators, which nobody controls. For this reason the comparison distance can be picked at run time from a small set of taps. Software, or a supervising block, keeps the tap whose totals sit near half the window length. Any total close to zero or close to the full window length is flagged so that it can be left out.

The input uses a valid/ready pair. Ready is always high, so the block never applies back-pressure, and a bit counts only in a cycle where valid is high. The result has a valid strobe and no ready. A consumer must capture it in the strobe cycle.

Top module: `mismatch_window_counter`

## Requirements
- R1: `bit_ready` is always 1. A bit is accepted on a rising clock edge where `bit_valid` is 1. Cycles where `bit_valid` is 0 change neither the history nor the window count.
- R2: After reset, the first MAX_DELAY accepted bits only fill the history and produce no result. MAX_DELAY is the longest tap, 303 by default. Counting starts with accepted bit MAX_DELAY+1.
- R3: Each window is WIN_LEN consecutive counted bits (136 by default). Windows follow each other with no gap and no overlap. `res_valid` is high for exactly one cycle, in the cycle right after the edge that accepts a window's last bit.
- R4: `res_count` is the number of bits b[j] in the window for which b[j] differs from b[j-D]. Here D is the window's active delay, counted in accepted bits. The value lies between 0 and WIN_LEN.
- R5: A tap index k on `tap_sel` selects the delay D = TAP_BASE + k*TAP_STEP. With the defaults, indices 0, 1, 2 and 3 give 297, 299, 301 and 303.
- R6: `tap_sel` is sampled only on the edge that accepts the last bit of a window, or the last filling bit. The value sampled there applies to the whole next window. `tap_sel` values at any other edge have no effect.
- R7: `res_edge` is 1 together with `res_valid` when res_count*8 < WIN_LEN or res_count*8 > 7*WIN_LEN. Otherwise it is 0, and it is never 1 without `res_valid`.
- R8: While reset is asserted and after it, until the first result, `res_valid`, `res_edge` and `res_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Sampler bit present this cycle |
| bit_data | input | 1 | Sampler bit |
| bit_ready | output | 1 | Always 1; the block never stalls the stream |
| tap_sel | input | 2 | Delay tap index for the next window |
| res_valid | output | 1 | One-cycle strobe for a finished window |
| res_count | output | 8 | Mismatch total of the finished window |
| res_edge | output | 1 | Total lies too near 0 or WIN_LEN |

## Verification
A window result is due one cycle after the edge that accepts the window's last bit. The bench drives each bit one time unit after a rising edge. At that moment it updates its own history model and queues the expected total and edge flag whenever the modelled window closes. A monitor samples at every falling edge. Each strobe it sees must match the head of that queue, and any strobe with an empty queue is reported, which covers the silent filling phase. Random `tap_sel` values in idle cycles and mid-window test that only boundary samples count. A few cycles after each phase ends, the queue must be empty, which shows that no window was dropped.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

  // Delay in accepted samples for tap index idx
  function automatic int tap_delay(input int base, input int step, input int idx);
    return base + idx * step;
  endfunction

  // True when a window total sits within one eighth of either rail
  function automatic logic near_rail(input int total, input int win);
    return ((total * 8) < win) || ((total * 8) > (7 * win));
  endfunction

endpackage

// File: rtl/mwc_delay_line.sv
module mwc_delay_line #(
  parameter int TAP_BASE = 297,
  parameter int TAP_STEP = 2,
  parameter int NUM_TAPS = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic [SEL_W-1:0] tap_idx,
  output logic             primed,
  output logic             delayed_bit
);
  import mwc_pkg::*;

  localparam int MAX_DELAY = tap_delay(TAP_BASE, TAP_STEP, NUM_TAPS - 1);
  localparam int FILL_W    = $clog2(MAX_DELAY + 1);

  logic [MAX_DELAY-1:0] hist_q;
  logic [FILL_W-1:0]    fill_q;
  logic [NUM_TAPS-1:0]  tap_bits;

  assign primed = (fill_q == FILL_W'(MAX_DELAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (in_valid) begin
      hist_q <= {hist_q[MAX_DELAY-2:0], in_bit};
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  // hist_q[0] holds the previous accepted bit, so index d-1 is d samples back
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_bits[g] = hist_q[tap_delay(TAP_BASE, TAP_STEP, g) - 1];
  end

  assign delayed_bit = tap_bits[tap_idx];

  AST_FILL_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed); // R2

endmodule

// File: rtl/mwc_window.sv
module mwc_window #(
  parameter int WIN_LEN = 136,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             primed,
  input  logic             mismatch,
  input  logic [SEL_W-1:0] tap_sel_in,
  output logic [SEL_W-1:0] tap_q,
  output logic             close_o,
  output logic [CNT_W-1:0] total_o,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_count
);
  localparam int POS_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] acc_q;
  logic             last_slot;

  assign last_slot = (pos_q == POS_W'(WIN_LEN - 1));
  assign total_o   = acc_q + CNT_W'(mismatch);
  assign close_o   = in_valid && primed && last_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      acc_q     <= '0;
      tap_q     <= '0;
      res_valid <= 1'b0;
      res_count <= '0;
    end else begin
      res_valid <= 1'b0;
      if (in_valid) begin
        if (!primed) begin
          tap_q <= tap_sel_in;
        end else if (last_slot) begin
          res_count <= total_o;
          res_valid <= 1'b1;
          acc_q     <= '0;
          pos_q     <= '0;
          tap_q     <= tap_sel_in;
        end else begin
          acc_q <= total_o;
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count <= CNT_W'(WIN_LEN))); // R4

  AST_QUIET_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !res_valid); // R2

endmodule

// File: rtl/mwc_rail_flag.sv
module mwc_rail_flag #(
  parameter int WIN_LEN = 136,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  output logic             flag_q
);
  import mwc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (load) flag_q <= near_rail(int'(total), WIN_LEN);
    else           flag_q <= 1'b0;
  end

endmodule

// File: rtl/mismatch_window_counter.sv
module mismatch_window_counter #(
  parameter int TAP_BASE = 297,
  parameter int TAP_STEP = 2,
  parameter int NUM_TAPS = 4,
  parameter int WIN_LEN  = 136,
  parameter int SEL_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
  parameter int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_count,
  output logic             res_edge
);
  logic             primed;
  logic             delayed_bit;
  logic [SEL_W-1:0] active_tap;
  logic             win_close;
  logic [CNT_W-1:0] win_total;

  assign bit_ready = 1'b1;

  mwc_delay_line #(
    .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP), .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)
  ) u_delay (
    .clk(clk), .rst_n(rst_n), .in_valid(bit_valid), .in_bit(bit_data),
    .tap_idx(active_tap), .primed(primed), .delayed_bit(delayed_bit)
  );

  mwc_window #(
    .WIN_LEN(WIN_LEN), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .in_valid(bit_valid), .primed(primed),
    .mismatch(bit_data ^ delayed_bit), .tap_sel_in(tap_sel), .tap_q(active_tap),
    .close_o(win_close), .total_o(win_total),
    .res_valid(res_valid), .res_count(res_count)
  );

  mwc_rail_flag #(
    .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)
  ) u_rail (
    .clk(clk), .rst_n(rst_n), .load(win_close), .total(win_total), .flag_q(res_edge)
  );

  AST_EDGE_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_edge |-> res_valid); // R7

endmodule

// File: tb/test_mismatch_window_counter.sv
module test_mismatch_window_counter;
  localparam int TB_BASE = 297;
  localparam int TB_STEP = 2;
  localparam int TB_TAPS = 4;
  localparam int TB_WIN  = 136;
  localparam int TB_MAXD = TB_BASE + (TB_TAPS - 1) * TB_STEP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [1:0] tap_sel = 2'd0;
  logic       res_valid;
  logic [7:0] res_count;
  logic       res_edge;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  bit hist[$];
  int exp_cnt[$];
  bit exp_edge[$];
  int m_pos, m_acc, m_tap, drv_tap;

  always #4 clk = ~clk;

  mismatch_window_counter i_mismatch_window_counter (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .tap_sel(tap_sel), .res_valid(res_valid),
    .res_count(res_count), .res_edge(res_edge)
  );

  function automatic bit exp_rail(input int c);
    return (c * 8 < TB_WIN) || (c * 8 > 7 * TB_WIN);
  endfunction

  // Reference model: called for each bit at the time it is driven as valid
  task automatic model_accept(input bit b, input int t);
    int j;
    j = hist.size();
    if (j < TB_MAXD) begin
      if (j == TB_MAXD - 1) m_tap = t;
    end else begin
      int d;
      d = TB_BASE + m_tap * TB_STEP;
      m_acc += (b != hist[j - d]) ? 1 : 0;
      if (m_pos == TB_WIN - 1) begin
        exp_cnt.push_back(m_acc);
        exp_edge.push_back(exp_rail(m_acc));
        m_acc = 0;
        m_pos = 0;
        m_tap = t;
      end else begin
        m_pos++;
      end
    end
    hist.push_back(b);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; bit_valid = 1'b0;
    hist.delete(); exp_cnt.delete(); exp_edge.delete();
    m_pos = 0; m_acc = 0; m_tap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_edge !== 1'b0 || res_count !== 8'd0) begin
      failures++;
      $display("FAIL R8 reset outputs valid=%b edge=%b count=%0d expected 0 0 0",
               res_valid, res_edge, res_count);
    end
    checks++;
    if (bit_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 bit_ready=%b expected 1", bit_ready);
    end
    rst_n = 1'b1;
  endtask

  // Idle cycles carry garbage data and random tap values, then one valid bit
  task automatic send_bit(input bit b, input int gap);
    for (int k = 0; k < gap; k++) begin
      @(posedge clk); #1;
      bit_valid = 1'b0;
      bit_data  = 1'($urandom);
      tap_sel   = 2'($urandom);
    end
    @(posedge clk); #1;
    bit_valid = 1'b1;
    bit_data  = b;
    tap_sel   = 2'(drv_tap);
    model_accept(b, drv_tap);
  endtask

  task automatic finish_phase(input string name);
    @(posedge clk); #1;
    bit_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_cnt.size() != 0) begin
      failures++;
      $display("FAIL R3 %s: %0d windows not reported, expected 0 outstanding",
               name, exp_cnt.size());
    end
  endtask

  // Monitor: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_edge && !res_valid) begin
        checks++; failures++;
        $display("FAIL R7 edge=1 with valid=0, expected edge only with valid");
      end
      if (bit_ready !== 1'b1) begin
        checks++; failures++;
        $display("FAIL R1 bit_ready=%b expected 1", bit_ready);
      end
      if (res_valid) begin
        checks++;
        if (exp_cnt.size() == 0) begin
          failures++;
          $display("FAIL R2 R3 unexpected result count=%0d, expected no strobe", res_count);
        end else begin
          int ec;
          bit ee;
          ec = exp_cnt.pop_front();
          ee = exp_edge.pop_front();
          if (int'(res_count) != ec) begin
            failures++;
            $display("FAIL R4 R5 R6 count=%0d expected %0d", res_count, ec);
          end
          checks++;
          if (res_edge !== ee) begin
            failures++;
            $display("FAIL R7 edge=%b expected %b (count %0d)", res_edge, ee, ec);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));

    // Alternating bits, odd delay: every pair differs -> full count, edge (R4 R5 R7)
    drv_tap = 0;
    do_reset();
    for (int i = 0; i < TB_MAXD + 2 * TB_WIN; i++) send_bit(1'(i % 2), 0);
    finish_phase("alternating");

    // All zeros with idle gaps: count 0, edge, gaps ignored (R1 R7)
    drv_tap = 3;
    do_reset();
    for (int i = 0; i < TB_MAXD + 2 * TB_WIN; i++) send_bit(1'b0, $urandom_range(0, 2));
    finish_phase("zeros");

    // Period-4 pattern with delay 299: half the pairs differ, no edge (R4 R5 R7)
    drv_tap = 1;
    do_reset();
    for (int i = 0; i < TB_MAXD + 3 * TB_WIN; i++) send_bit(1'((i % 4) >= 2), 0);
    finish_phase("period4");

    // Period-4 pattern, tap changed mid-window only: sampled at boundary (R6)
    drv_tap = 2;
    do_reset();
    for (int i = 0; i < TB_MAXD + 4 * TB_WIN; i++) begin
      if (i == TB_MAXD + TB_WIN + 40) drv_tap = 0;
      send_bit(1'((i % 4) >= 2), $urandom_range(0, 1));
    end
    finish_phase("tap_switch");

    // Constrained random bits, gaps and tap changes (R1 R2 R3 R4 R6)
    drv_tap = 1;
    do_reset();
    for (int i = 0; i < TB_MAXD + 30 * TB_WIN; i++) begin
      if ($urandom_range(0, 63) == 0) drv_tap = $urandom_range(0, 3);
      send_bit(1'($urandom), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
    end
    finish_phase("random");

    // Biased random stream near a rail to exercise edge thresholds (R7)
    drv_tap = 2;
    do_reset();
    for (int i = 0; i < TB_MAXD + 6 * TB_WIN; i++)
      send_bit(($urandom_range(0, 15) == 0) ? 1'b1 : 1'b0, 0);
    finish_phase("biased");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule